// File: doc/BRIEF.md
# Serial Daisy-Chain Configuration Loader

This block takes the setup image of a multi-queue buffer from a single-bit serial stream. The image holds each queue's block allocation and its almost-full and almost-empty thresholds. While a device is loading, every enabled serial clock shifts one bit into a long shift register, and a counter tracks how many bits have arrived. When the count reaches the fixed image length, the device freezes its image. It then routes its serial data input straight to its serial data output and drops its enable output. The next device in the chain sees that low enable and starts loading from the same line.

Each device wires its serial enable output to the enable input of the next device, and its serial data output to the next device's data input. The parallel image is presented to the queue logic at all times. Write-port queue selection is gated off until this device has finished loading. Master reset restores a default image in which every queue gets an equal share of the memory blocks. The serial interface is a plain clocked line with no back-pressure. Each enabled clock consumes exactly one bit, and the sender cannot be stalled.

Top module: `cfg_chain_loader`

## Requirements
- R1: While `rst_n` is low, the image loads defaults: every queue gets TOTAL_BLOCKS/NUM_Q blocks, almost-full threshold DEF_AF and almost-empty threshold DEF_AE. The bit count clears and `cfg_done` is 0.
- R2: A rising `clk` with `ser_en_n` high leaves the image and the bit count unchanged.
- R3: `ser_en_out_n` is 0 only when `cfg_done` is 1 and `ser_en_n` is 0; otherwise it is 1.
- R4: On each rising `clk` with `ser_en_n` low and `cfg_done` 0, one bit is taken. `cfg_done` rises on the edge that takes bit number CFG_LEN = NUM_Q*(BLK_W+2*THR_W).
- R5: Once `cfg_done` is 1, the image no longer changes, whatever arrives on `ser_in`, until reset.
- R6: `ser_out` equals `ser_in` combinationally while `cfg_done` is 1 and is 0 while loading.
- R7: `wsel_ok` equals `wsel_req` while `cfg_done` is 1 and is 0 before that.
- R8: Each taken bit enters image bit 0 while all earlier bits move up one place, so the first bit of a full load ends at bit CFG_LEN-1. Queue q owns image bits [q*E +: E], where E = BLK_W+2*THR_W. Within that slice, the almost-empty threshold sits in the low THR_W bits, the almost-full threshold above it, and the block count at the top. The three output buses are the per-queue fields concatenated, with queue 0 in the least significant place.
- R9: A reset in the middle of a load restores the defaults, and the next load again needs the full CFG_LEN bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| ser_in | input | 1 | Serial data in |
| ser_en_n | input | 1 | Serial enable in, active low |
| ser_out | output | 1 | Serial data out to the next device |
| ser_en_out_n | output | 1 | Serial enable out to the next device, active low |
| cfg_done | output | 1 | Image is complete and frozen |
| wsel_req | input | 1 | Write-port queue selection request |
| wsel_ok | output | 1 | Selection request let through |
| cfg_blocks | output | NUM_Q*BLK_W | Block count per queue |
| cfg_af | output | NUM_Q*THR_W | Almost-full threshold per queue |
| cfg_ae | output | NUM_Q*THR_W | Almost-empty threshold per queue |

## Verification
A bit counter that is off by one makes `cfg_done` rise a clock too early or too late. That error shows at once on `ser_en_out_n`, `wsel_ok` and `ser_out`, and it leaves a shifted image on the field buses. A shifter that keeps running after completion, or that moves while the enable is high, corrupts the field buses on the next clock. Because every output is compared on every clock against a behavioural model, any such slip is seen within one cycle of the edge that caused it.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  function automatic int equal_share(input int total, input int parts);
    return (parts > 0) ? total / parts : 0;
  endfunction

  function automatic int entry_width(input int blk_w, input int thr_w);
    return blk_w + 2 * thr_w;
  endfunction
endpackage

// File: rtl/cfg_len_counter.sv
module cfg_len_counter #(
  parameter int LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en_n,
  output logic take,
  output logic done
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] count;

  assign take = ~ser_en_n & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else if (take) begin
      count <= count + 1'b1;
      if (count == CW'(LEN - 1)) done <= 1'b1;
    end
  end

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en_n |=> $stable(count));
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CW'(LEN)));
endmodule

// File: rtl/cfg_shift_image.sv
module cfg_shift_image #(
  parameter int LEN = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           bit_in,
  input  logic [LEN-1:0] defaults,
  output logic [LEN-1:0] image
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    image <= defaults;
    else if (take) image <= {image[LEN-2:0], bit_in};
  end

  p_image_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(image));
  p_bit_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> image[0] == $past(bit_in));
endmodule

// File: rtl/cfg_chain_port.sv
module cfg_chain_port (
  input  logic done,
  input  logic ser_in,
  input  logic ser_en_n,
  input  logic wsel_req,
  output logic ser_out,
  output logic ser_en_out_n,
  output logic wsel_ok
);
  always_comb begin
    ser_out      = done & ser_in;
    ser_en_out_n = ser_en_n | ~done;
    wsel_ok      = wsel_req & done;
  end
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
  import cfg_loader_pkg::*;
#(
  parameter int NUM_Q        = 4,
  parameter int BLK_W        = 6,
  parameter int THR_W        = 5,
  parameter int TOTAL_BLOCKS = 32,
  parameter int DEF_AF       = 3,
  parameter int DEF_AE       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_in,
  input  logic                   ser_en_n,
  output logic                   ser_out,
  output logic                   ser_en_out_n,
  output logic                   cfg_done,
  input  logic                   wsel_req,
  output logic                   wsel_ok,
  output logic [NUM_Q*BLK_W-1:0] cfg_blocks,
  output logic [NUM_Q*THR_W-1:0] cfg_af,
  output logic [NUM_Q*THR_W-1:0] cfg_ae
);
  localparam int EW      = entry_width(BLK_W, THR_W);
  localparam int CFG_LEN = NUM_Q * EW;
  localparam int SHARE   = equal_share(TOTAL_BLOCKS, NUM_Q);

  logic [CFG_LEN-1:0] defaults;
  logic [CFG_LEN-1:0] image;
  logic               take;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    assign defaults[q*EW +: EW] = {BLK_W'(SHARE), THR_W'(DEF_AF), THR_W'(DEF_AE)};
    assign cfg_ae[q*THR_W +: THR_W]     = image[q*EW +: THR_W];
    assign cfg_af[q*THR_W +: THR_W]     = image[q*EW + THR_W +: THR_W];
    assign cfg_blocks[q*BLK_W +: BLK_W] = image[q*EW + 2*THR_W +: BLK_W];
  end

  cfg_len_counter #(.LEN(CFG_LEN)) u_count (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .take(take), .done(cfg_done)
  );

  cfg_shift_image #(.LEN(CFG_LEN)) u_image (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(ser_in),
    .defaults(defaults), .image(image)
  );

  cfg_chain_port u_port (
    .done(cfg_done), .ser_in(ser_in), .ser_en_n(ser_en_n), .wsel_req(wsel_req),
    .ser_out(ser_out), .ser_en_out_n(ser_en_out_n), .wsel_ok(wsel_ok)
  );

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (ser_out == ser_in));
  p_rise_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> !$past(ser_en_n));
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_done) |-> $stable(cfg_blocks) && $stable(cfg_af) && $stable(cfg_ae));
  p_sel_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !wsel_ok && ser_en_out_n);
endmodule

// File: tb/test_cfg_chain_loader.sv
module test_cfg_chain_loader;
  localparam int PER = 10;
  localparam int NQ = 4, BW = 6, TW = 5, TOT = 32, DAF = 3, DAE = 2;
  localparam int EW = BW + 2*TW;
  localparam int L  = NQ * EW;

  logic clk = 0, rst_n = 0, ser_in = 0, ser_en_n = 1, wsel_req = 0;
  logic ser_out, ser_en_out_n, cfg_done, wsel_ok;
  logic [NQ*BW-1:0] cfg_blocks;
  logic [NQ*TW-1:0] cfg_af, cfg_ae;

  int total = 0, bad = 0;
  logic [L-1:0] m_img;
  int m_cnt;
  bit m_done;

  always #(PER/2) clk = ~clk;

  cfg_chain_loader i_cfg_chain_loader (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_en_n(ser_en_n),
    .ser_out(ser_out), .ser_en_out_n(ser_en_out_n), .cfg_done(cfg_done),
    .wsel_req(wsel_req), .wsel_ok(wsel_ok),
    .cfg_blocks(cfg_blocks), .cfg_af(cfg_af), .cfg_ae(cfg_ae)
  );

  function automatic logic [L-1:0] defaults_img();
    logic [L-1:0] v = '0;
    for (int q = 0; q < NQ; q++) begin
      v[q*EW + 2*TW +: BW] = BW'(TOT / NQ);
      v[q*EW + TW +: TW]   = TW'(DAF);
      v[q*EW +: TW]        = TW'(DAE);
    end
    return v;
  endfunction

  // behavioural reference (R1, R2, R4, R5, R8, R9)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_img = defaults_img(); m_cnt = 0; m_done = 0;
    end else if (!m_done && !ser_en_n) begin
      m_img = {m_img[L-2:0], ser_in};
      m_cnt = m_cnt + 1;
      if (m_cnt == L) m_done = 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [NQ*BW-1:0] eb; logic [NQ*TW-1:0] ef, ee;
    for (int q = 0; q < NQ; q++) begin
      eb[q*BW +: BW] = m_img[q*EW + 2*TW +: BW];
      ef[q*TW +: TW] = m_img[q*EW + TW +: TW];
      ee[q*TW +: TW] = m_img[q*EW +: TW];
    end
    chk("R4 done", 64'(cfg_done), 64'(m_done));
    chk("R3 en_out", 64'(ser_en_out_n), 64'(ser_en_n | !m_done));
    chk("R6 ser_out", 64'(ser_out), 64'(m_done & ser_in));
    chk("R7 wsel_ok", 64'(wsel_ok), 64'(wsel_req & m_done));
    chk("R8 blocks", 64'(cfg_blocks), 64'(eb));
    chk("R8 af", 64'(cfg_af), 64'(ef));
    chk("R8 ae", 64'(cfg_ae), 64'(ee));
  end

  task automatic drive(input logic b, input logic en_n, input logic sel);
    @(negedge clk); #2;
    ser_in = b; ser_en_n = en_n; wsel_req = sel;
  endtask

  initial begin
    #(PER*200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;                                   // R1 defaults seen on first compares
    for (int i = 0; i < 6; i++) drive(i[0], 1, i[1]);   // R2 idle, R7 gated
    for (int i = 0; i < 20; i++) drive((i*5 + 3) % 7 > 3, 0, i[0]);
    for (int i = 0; i < 4; i++) drive(1, 1, 1);        // R2 pause mid-load
    for (int i = 20; i < L; i++) drive((i*5 + 3) % 7 > 3, 0, 1); // R4 completion
    for (int i = 0; i < 12; i++) drive(i[0] ^ i[2], 0, i[1]);    // R5 ignored, R6 pass
    for (int i = 0; i < 4; i++) drive(1, 1, 1);        // R3 tracks enable high
    drive(0, 0, 0);
    // R9: reset mid-load then full reload
    @(negedge clk); #2 rst_n = 0;
    @(negedge clk); #2 rst_n = 1;
    for (int i = 0; i < 10; i++) drive(1, 0, 1);
    @(negedge clk); #2 rst_n = 0;
    @(negedge clk); #2 rst_n = 1;
    for (int i = 0; i < L - 1; i++) drive(i[0] | i[3], 0, 1);
    drive(1, 1, 1);                                // one short: not done yet
    drive(1, 0, 1);                                // last bit
    for (int i = 0; i < 6; i++) drive(i[0], 0, 1);
    drive(0, 1, 0);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule